// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs on the host side of a byte-wide parallel flash device and drives it through a synchronous bus master port. The port has an address, write data, read data, an active-low write strobe and an active-low read strobe. A client hands the block one request at a time: a byte program, a sector erase or a whole-device erase, together with a target address and a data byte. The block then writes the unlock and command bytes the device expects and polls the device until the embedded operation finishes. It reports the outcome with a one-cycle completion pulse, an error flag and a data byte.

Two ways of detecting completion are available, chosen per request. In data-polling mode the block watches bit 7 of the byte read back. In toggle mode it watches bit 6 on back-to-back reads. A cycle budget bounds polling in both modes, with separate budgets for programming and for erasing. Bit 7 can settle before the lower bits do. For that reason, once polling sees completion, the block always makes one more read and returns that value as the result.

Top module: `flash_seq`

## Requirements
- R1: After reset the block has request-ready high, both strobes high and the completion pulse low.
- R2: A program request (operation code 0) writes, in order, 05555h/AAh, 02AAAh/55h and 05555h/A0h, and then the request address with the request data.
- R3: A sector erase request (operation code 1) writes 05555h/AAh, 02AAAh/55h, 05555h/80h, 05555h/AAh and 02AAAh/55h, and then the request address with 30h.
- R4: A device erase request (operation code 2) writes the same five-byte prefix as R3, and then 05555h/10h.
- R5: Each write holds the write strobe low for at least STROBE_CYC clock cycles. Address and write data stay stable while the strobe is low, and the two strobes are never low together.
- R6: With the toggle-select input low, every poll read uses the request address. Polling ends on the first read whose bit 7 equals the expected value: bit 7 of the request data for a program, or 1 for either erase.
- R7: With the toggle-select input high, polling ends on the first read whose bit 6 equals bit 6 of the read just before it in the same request.
- R8: After polling ends, the block makes exactly one more read at the request address. It reports that read's byte with the completion pulse and the error flag low.
- R9: If polling has lasted at least PROG_LIMIT cycles (program) or ERASE_LIMIT cycles (erase) when a poll read fails to match, the completion pulse carries the error flag high. An erase that finishes between the two limits does not flag an error.
- R10: Request-ready is high only while idle, so it drops the cycle after a request is accepted. The completion pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 device erase |
| req_toggle | input | 1 | 1 selects toggle-bit completion, 0 selects bit-7 polling |
| req_addr | input | 18 | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Polling budget ran out (valid with done) |
| done_data | output | 8 | Byte from the final read (valid with done) |
| mem_addr | output | 18 | Flash bus address |
| mem_wdata | output | 8 | Flash bus write data |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_rdata | input | 8 | Flash bus read data |

## Verification
Each bus access takes 2 + STROBE_CYC + RECOV_CYC cycles, from the idle cycle in which the sequencer starts it to the end of recovery. The completion pulse is registered and appears one cycle after the recovery of the final read. No result has a fixed latency, so the bench never waits a counted number of cycles. Its monitors sample on the falling clock edge: a write is compared when its strobe is seen to rise, a poll address when the read strobe is seen to fall, and a result when the completion pulse is seen. Each is popped from the queue the driver filled for that request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int FS_ADDR_W = 18;
  localparam int FS_DATA_W = 8;
  localparam int FS_STEP_W = 3;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_e;

  // number of command writes before polling
  function automatic logic [FS_STEP_W-1:0] cmd_len(op_e op);
    return (op == OP_PROG) ? FS_STEP_W'(4) : FS_STEP_W'(6);
  endfunction

  function automatic logic [FS_ADDR_W-1:0] cmd_addr(op_e op, logic [FS_STEP_W-1:0] step,
                                                    logic [FS_ADDR_W-1:0] ua);
    logic [FS_ADDR_W-1:0] a;
    case (step)
      3'd0, 3'd2: a = FS_ADDR_W'(18'h05555);
      3'd1, 3'd4: a = FS_ADDR_W'(18'h02AAA);
      3'd3:       a = (op == OP_PROG) ? ua : FS_ADDR_W'(18'h05555);
      default:    a = (op == OP_CHIP) ? FS_ADDR_W'(18'h05555) : ua;
    endcase
    return a;
  endfunction

  function automatic logic [FS_DATA_W-1:0] cmd_data(op_e op, logic [FS_STEP_W-1:0] step,
                                                    logic [FS_DATA_W-1:0] ud);
    logic [FS_DATA_W-1:0] d;
    case (step)
      3'd0:    d = 8'hAA;
      3'd1:    d = 8'h55;
      3'd2:    d = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3:    d = (op == OP_PROG) ? ud : 8'hAA;
      3'd4:    d = 8'h55;
      default: d = (op == OP_CHIP) ? 8'h10 : 8'h30;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/flash_seq_bus.sv
module flash_seq_bus
  import flash_seq_pkg::*;
#(
  parameter int STROBE_CYC = 5,
  parameter int RECOV_CYC  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wr,
  input  logic [FS_ADDR_W-1:0] addr_in,
  input  logic [FS_DATA_W-1:0] data_in,
  output logic                 idle,
  output logic                 done,
  output logic [FS_DATA_W-1:0] rdata_out,
  output logic [FS_ADDR_W-1:0] mem_addr,
  output logic [FS_DATA_W-1:0] mem_wdata,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  input  logic [FS_DATA_W-1:0] mem_rdata
);
  localparam int MAXC = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bst_e;

  bst_e                 st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 wr_q;
  logic [FS_ADDR_W-1:0] addr_q;
  logic [FS_DATA_W-1:0] data_q, rd_q;
  logic                 load, cap;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    cap   = 1'b0;
    done  = 1'b0;
    case (st_q)
      B_IDLE: if (start) begin
        load = 1'b1;
        st_d = B_SETUP;
      end
      B_SETUP: begin
        st_d  = B_STROBE;
        cnt_d = '0;
      end
      B_STROBE: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(STROBE_CYC - 1)) begin
          cap   = ~wr_q;
          st_d  = B_RECOV;
          cnt_d = '0;
        end
      end
      default: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(RECOV_CYC - 1)) begin
          done = 1'b1;
          st_d = B_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (load) begin
        wr_q   <= wr;
        addr_q <= addr_in;
        data_q <= wr ? data_in : '0;
      end
      if (cap) rd_q <= mem_rdata;
    end
  end

  assign idle      = (st_q == B_IDLE);
  assign rdata_out = rd_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_we_n  = ~((st_q == B_STROBE) && wr_q);
  assign mem_oe_n  = ~((st_q == B_STROBE) && !wr_q);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n || mem_oe_n));
  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll
  import flash_seq_pkg::*;
#(
  parameter int PROG_LIMIT  = 2500,
  parameter int ERASE_LIMIT = 10000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 run,
  input  logic                 sample,
  input  logic [FS_DATA_W-1:0] rdata,
  input  logic                 toggle_mode,
  input  logic                 exp7,
  input  logic                 erase,
  output logic                 hit,
  output logic                 expired
);
  localparam int MAXL = (ERASE_LIMIT > PROG_LIMIT) ? ERASE_LIMIT : PROG_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          prev6_q, have_q;

  assign limit   = erase ? CW'(ERASE_LIMIT) : CW'(PROG_LIMIT);
  assign expired = (cnt_q >= limit);
  assign hit     = toggle_mode ? (have_q && (rdata[6] == prev6_q)) : (rdata[7] == exp7);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clear) begin
        have_q  <= 1'b0;
        prev6_q <= 1'b0;
      end else if (sample) begin
        have_q  <= 1'b1;
        prev6_q <= rdata[6];
      end
    end
  end

  // R9
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int STROBE_CYC  = 5,
  parameter int RECOV_CYC   = 5,
  parameter int PROG_LIMIT  = 2500,
  parameter int ERASE_LIMIT = 10000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic                 req_toggle,
  input  logic [FS_ADDR_W-1:0] req_addr,
  input  logic [FS_DATA_W-1:0] req_data,
  output logic                 done,
  output logic                 done_err,
  output logic [FS_DATA_W-1:0] done_data,
  output logic [FS_ADDR_W-1:0] mem_addr,
  output logic [FS_DATA_W-1:0] mem_wdata,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  input  logic [FS_DATA_W-1:0] mem_rdata
);
  typedef enum logic [1:0] {T_IDLE, T_CMD, T_POLL, T_FINAL} tst_e;

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  tst_e                 st_q, st_d;
  op_e                  op_q;
  logic                 tog_q;
  logic [FS_ADDR_W-1:0] addr_q;
  logic [FS_DATA_W-1:0] data_q, val_q, val_d;
  logic [FS_STEP_W-1:0] step_q, step_d;
  logic                 done_q, done_d, err_q, err_d, res_en;
  logic                 accept;

  logic                 bus_start, bus_idle, bus_done;
  logic [FS_ADDR_W-1:0] bus_addr;
  logic [FS_DATA_W-1:0] bus_wdata, bus_rdata;
  logic                 hit, expired;

  assign accept    = (st_q == T_IDLE) && req_valid;
  assign bus_start = (st_q != T_IDLE) && bus_idle;
  assign bus_addr  = (st_q == T_CMD) ? cmd_addr(op_q, step_q, addr_q) : addr_q;
  assign bus_wdata = (st_q == T_CMD) ? cmd_data(op_q, step_q, data_q) : '0;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    done_d = 1'b0;
    err_d  = err_q;
    val_d  = val_q;
    res_en = 1'b0;
    case (st_q)
      T_IDLE: if (accept) begin
        st_d   = T_CMD;
        step_d = '0;
      end
      T_CMD: if (bus_done) begin
        if (step_q == cmd_len(op_q) - 1'b1) st_d = T_POLL;
        else                                step_d = step_q + 1'b1;
      end
      T_POLL: if (bus_done) begin
        if (hit) st_d = T_FINAL;
        else if (expired) begin
          st_d   = T_IDLE;
          done_d = 1'b1;
          res_en = 1'b1;
          err_d  = 1'b1;
          val_d  = bus_rdata;
        end
      end
      default: if (bus_done) begin
        st_d   = T_IDLE;
        done_d = 1'b1;
        res_en = 1'b1;
        err_d  = 1'b0;
        val_d  = bus_rdata;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      step_q <= '0;
      op_q   <= OP_PROG;
      tog_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      done_q <= done_d;
      if (accept) begin
        op_q   <= op_e'(req_op);
        tog_q  <= req_toggle;
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (res_en) begin
        err_q <= err_d;
        val_q <= val_d;
      end
    end
  end

  flash_seq_bus #(.STROBE_CYC(STROBE_CYC), .RECOV_CYC(RECOV_CYC)) u_bus (
    .clk(clk), .rst_n(rst_ni), .start(bus_start), .wr(st_q == T_CMD),
    .addr_in(bus_addr), .data_in(bus_wdata), .idle(bus_idle), .done(bus_done),
    .rdata_out(bus_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata)
  );

  flash_seq_poll #(.PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_ni), .clear(accept), .run(st_q == T_POLL),
    .sample((st_q == T_POLL) && bus_done), .rdata(bus_rdata), .toggle_mode(tog_q),
    .exp7((op_q == OP_PROG) ? data_q[7] : 1'b1), .erase(op_q != OP_PROG),
    .hit(hit), .expired(expired)
  );

  assign req_ready = (st_q == T_IDLE);
  assign done      = done_q;
  assign done_err  = err_q;
  assign done_data = val_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_ready && req_valid) |=> !req_ready);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> (mem_we_n && mem_oe_n));
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int ST = 5;
  localparam int RC = 5;
  localparam int PL = 300;
  localparam int EL = 900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        req_toggle = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        done, done_err;
  logic [7:0]  done_data;
  logic [17:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we_n, mem_oe_n;
  logic [7:0]  mem_rdata = '0;

  always #10 clk = ~clk;

  flash_seq #(.STROBE_CYC(ST), .RECOV_CYC(RC), .PROG_LIMIT(PL), .ERASE_LIMIT(EL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_toggle(req_toggle), .req_addr(req_addr), .req_data(req_data),
    .done(done), .done_err(done_err), .done_data(done_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R2";
  string res_req = "R8";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder state
  int         busy_left = 0;
  bit         early = 1'b0;
  bit         r_tog = 1'b0;
  logic       r_exp7 = 1'b0;
  logic [7:0] r_final = 8'hFF;
  logic [17:0] poll_addr = '0;
  int         reads = 0;

  always @(negedge mem_oe_n) begin
    reads++;
    if (busy_left > 0) begin
      busy_left--;
      mem_rdata = {~r_exp7, r_tog, 6'h15};
      r_tog = ~r_tog;
    end else if (early) begin
      early = 1'b0;
      mem_rdata = {r_exp7, ~r_final[6:0]};
    end else begin
      mem_rdata = r_final;
    end
  end

  // scoreboard queues
  logic [25:0] exp_wr_q[$];
  logic [9:0]  exp_res_q[$];   // {check value, err, value}

  // write and read monitor
  int          lowcnt = 0;
  bit          stable_ok = 1'b1;
  logic [17:0] cap_a;
  logic [7:0]  cap_d;
  logic        prev_oe = 1'b1;
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        if (lowcnt == 0) begin
          cap_a = mem_addr;
          cap_d = mem_wdata;
          stable_ok = 1'b1;
        end else if (mem_addr != cap_a || mem_wdata != cap_d) stable_ok = 1'b0;
        lowcnt++;
      end else if (lowcnt > 0) begin
        chk(lowcnt >= ST && stable_ok, "R5", lowcnt, ST);
        if (exp_wr_q.size() == 0) chk(1'b0, cur_req, {cap_a, cap_d}, 0);
        else begin
          logic [25:0] e;
          e = exp_wr_q.pop_front();
          chk({cap_a, cap_d} == e, cur_req, {cap_a, cap_d}, e);
        end
        lowcnt = 0;
      end
      if (!mem_oe_n && prev_oe)
        chk(mem_addr == poll_addr, "R6", mem_addr, poll_addr);
      prev_oe = mem_oe_n;
      if (prev_done) chk(!done, "R10", done, 0);
      if (done) begin
        if (exp_res_q.size() == 0) chk(1'b0, res_req, done_data, 0);
        else begin
          logic [9:0] r;
          r = exp_res_q.pop_front();
          chk(done_err == r[8], res_req, done_err, r[8]);
          if (r[9]) chk(done_data == r[7:0], res_req, done_data, r[7:0]);
        end
      end
      prev_done = done;
    end
  end

  task automatic push_wr(input logic [17:0] a, input logic [7:0] d);
    exp_wr_q.push_back({a, d});
  endtask

  // op: 0 program, 1 sector erase, 2 device erase
  task automatic run_op(input logic [1:0] op, input bit tog, input logic [17:0] a,
                        input logic [7:0] d, input int busy, input bit erly,
                        input bit exp_err, input string wreq, input string rreq);
    logic e7;
    logic [7:0] fin;
    e7  = (op == 2'd0) ? d[7] : 1'b1;
    fin = (op == 2'd0) ? d : 8'hFF;
    busy_left = busy; early = erly; r_tog = 1'b0; r_exp7 = e7; r_final = fin;
    poll_addr = a; cur_req = wreq; res_req = rreq; reads = 0;
    push_wr(18'h05555, 8'hAA);
    push_wr(18'h02AAA, 8'h55);
    if (op == 2'd0) begin
      push_wr(18'h05555, 8'hA0);
      push_wr(a, d);
    end else begin
      push_wr(18'h05555, 8'h80);
      push_wr(18'h05555, 8'hAA);
      push_wr(18'h02AAA, 8'h55);
      if (op == 2'd1) push_wr(a, 8'h30);
      else            push_wr(18'h05555, 8'h10);
    end
    exp_res_q.push_back({~exp_err, exp_err, fin});
    @(negedge clk);
    req_op = op; req_toggle = tog; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", req_ready, 0);
    while (exp_res_q.size() != 0) @(negedge clk);
    chk(exp_wr_q.size() == 0, wreq, exp_wr_q.size(), 0);
    exp_wr_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready, "R1", req_ready, 1);
    chk(mem_we_n && mem_oe_n, "R1", {mem_we_n, mem_oe_n}, 3);
    chk(!done, "R1", done, 0);
    // R2 R6 R8: program, bit7 settles before the low bits
    run_op(2'd0, 1'b0, 18'h1234A, 8'h5C, 4, 1'b1, 1'b0, "R2", "R8");
    // R2 R6: completes on the first poll read
    run_op(2'd0, 1'b0, 18'h3FFFF, 8'hA7, 0, 1'b0, 1'b0, "R2", "R6");
    // R3 R6 R8: sector erase, data polling
    run_op(2'd1, 1'b0, 18'h21000, 8'h00, 6, 1'b1, 1'b0, "R3", "R8");
    // R4 R7: device erase, toggle mode
    run_op(2'd2, 1'b1, 18'h00010, 8'h00, 5, 1'b0, 1'b0, "R4", "R7");
    // R2 R7 R8: program, toggle mode
    run_op(2'd0, 1'b1, 18'h00777, 8'h81, 3, 1'b1, 1'b0, "R2", "R7");
    // R9: program that never completes
    run_op(2'd0, 1'b0, 18'h00100, 8'h33, 1000000, 1'b0, 1'b1, "R2", "R9");
    chk(reads * (2 + ST + RC) >= PL, "R9", reads * (2 + ST + RC), PL);
    // R9: erase slower than the program budget still succeeds
    run_op(2'd1, 1'b0, 18'h3A000, 8'h00, 50, 1'b0, 1'b0, "R3", "R9");
    // R9: erase that never completes
    run_op(2'd1, 1'b0, 18'h38000, 8'h00, 1000000, 1'b0, 1'b1, "R3", "R9");
    chk(reads * (2 + ST + RC) >= EL, "R9", reads * (2 + ST + RC), EL);
    repeat (5) @(negedge clk);
    chk(req_ready, "R10", req_ready, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule